// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides when a small 32-bit RISC core must leave its instruction stream for an exception handler. It also performs the state changes that entry requires. Three maskable sources raise requests that stay latched until serviced: an external interrupt, a decrementer expiry and a system management interrupt. Two synchronous events arrive as single-cycle strobes from the execute stage: a program trap and a system call.

When an entry is taken, the block saves the return address and a filtered copy of the machine state word into two save/restore registers. It then rewrites the machine state word into handler mode and computes the handler address. A one-cycle redirect strobe tells the fetch stage to flush and restart at that address. The core updates the machine state word through a write port. The block owns the register, so that entry and software writes cannot race.

After reset, the redirect address output already holds the boot address. Fetch can start from it without waiting for a strobe.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, redirect_pc_o is 0xFFF00100, msr_o is 0x00000040, pending_o is 0, impl_cfg_o is 1 and redirect_o is low.
- R2: A one-cycle high on ext_req_i, dec_req_i or smi_req_i sets pending bit 0, 1 or 2 respectively at the next clock edge. The bit stays set until that source is serviced.
- R3: A pending source is never serviced while msr_o bit 15 (interrupt enable) is 0.
- R4: With interrupt enable set and several bits pending, bit 0 is serviced first, then bit 1, then bit 2. Each entry clears only the serviced bit.
- R5: A trap or system call is taken whatever the interrupt enable state. It wins over a pending maskable source in the same cycle and leaves pending_o unchanged. If trap_i and syscall_i are both high, the trap is taken.
- R6: On entry, srr1_o becomes the old machine state ANDed with 0x0000FF73. For a trap, bit 17 (0x00020000) is also set.
- R7: On entry, srr0_o becomes cur_pc_i for a trap and nxt_pc_i for every other kind.
- R8: On entry, msr_o bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 are cleared. Bit 0 takes the old value of bit 16, and all other bits are kept.
- R9: The handler offset is 0x0500 for external, 0x0900 for decrementer, 0x1400 for system management, 0x0700 for trap and 0x0C00 for system call. If old msr bit 6 is set, redirect_pc_o is 0xFFF00000 ORed with the offset; otherwise it is ibr_i ORed with the offset.
- R10: redirect_o is high for exactly the one cycle after each clock edge at which an entry is taken, and low otherwise.
- R11: msr_we_i loads msr_wdata_i at the clock edge when no entry is taken. If an entry is taken at that edge, the entry rewrite wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_i | input | 1 | External interrupt request pulse |
| dec_req_i | input | 1 | Decrementer expiry pulse |
| smi_req_i | input | 1 | System management interrupt pulse |
| trap_i | input | 1 | Program trap strobe |
| syscall_i | input | 1 | System call strobe |
| cur_pc_i | input | 32 | Address of the instruction now executing |
| nxt_pc_i | input | 32 | Address of the next instruction |
| ibr_i | input | 32 | Programmable handler base |
| msr_we_i | input | 1 | Machine state write enable |
| msr_wdata_i | input | 32 | Machine state write data |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | 32 | Handler address, boot address after reset |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved filtered machine state |
| msr_o | output | 32 | Current machine state word |
| pending_o | output | 3 | Latched maskable requests (bit 0 external, 1 decrementer, 2 system management) |
| impl_cfg_o | output | 32 | Implementation configuration word |

## Verification
A request pulse that is present at a clock edge shows in pending_o right after that edge. A maskable entry is decided from the registered pending bits and the registered interrupt enable, so it lands one edge later. A machine state write likewise lands one edge before the entry that depends on it. Trap and system-call strobes are acted on at the edge where they are sampled, and all entry results appear together right after that edge. The bench changes inputs on falling edges and reads outputs at the next falling edge, counting one edge per register stage.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int N_MASKABLE = 3;

  typedef enum logic [2:0] {
    EK_NONE = 3'd0,
    EK_EXT  = 3'd1,
    EK_DEC  = 3'd2,
    EK_SMI  = 3'd3,
    EK_TRAP = 3'd4,
    EK_SC   = 3'd5
  } exc_kind_e;

  // machine state bit positions
  localparam int MB_LE  = 0;
  localparam int MB_RI  = 1;
  localparam int MB_DR  = 4;
  localparam int MB_IR  = 5;
  localparam int MB_IP  = 6;
  localparam int MB_FE1 = 8;
  localparam int MB_BE  = 9;
  localparam int MB_SE  = 10;
  localparam int MB_FE0 = 11;
  localparam int MB_FP  = 13;
  localparam int MB_PR  = 14;
  localparam int MB_EE  = 15;
  localparam int MB_ILE = 16;
  localparam int MB_POW = 18;

  localparam logic [31:0] SRR1_KEEP = 32'h0000_FF73;
  localparam int          SRR1_TRAP_BIT = 17;

  function automatic logic [31:0] entry_clear_mask();
    logic [31:0] m;
    m = '0;
    m[MB_POW] = 1'b1; m[MB_EE]  = 1'b1; m[MB_PR]  = 1'b1; m[MB_FP] = 1'b1;
    m[MB_FE0] = 1'b1; m[MB_SE]  = 1'b1; m[MB_BE]  = 1'b1; m[MB_FE1] = 1'b1;
    m[MB_IR]  = 1'b1; m[MB_DR]  = 1'b1; m[MB_RI]  = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] msr_on_entry(input logic [31:0] msr);
    logic [31:0] r;
    r = msr & ~entry_clear_mask();
    r[MB_LE] = msr[MB_ILE];
    return r;
  endfunction

  function automatic logic [31:0] srr1_on_entry(input logic [31:0] msr, input logic is_trap);
    logic [31:0] r;
    r = msr & SRR1_KEEP;
    r[SRR1_TRAP_BIT] = is_trap;
    return r;
  endfunction

  function automatic logic [15:0] vec_offset(input exc_kind_e k);
    case (k)
      EK_EXT:  return 16'h0500;
      EK_DEC:  return 16'h0900;
      EK_SMI:  return 16'h1400;
      EK_TRAP: return 16'h0700;
      EK_SC:   return 16'h0C00;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [31:0] vector_addr(input logic [31:0] msr, input logic [31:0] ibr,
                                              input logic [15:0] off, input logic [31:0] hi_base);
    logic [31:0] base;
    base = msr[MB_IP] ? hi_base : ibr;
    return base | {16'h0000, off};
  endfunction

endpackage

// File: rtl/exc_pend_reg.sv
module exc_pend_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_o[g] <= 1'b0;
      else if (set_i[g])   pend_o[g] <= 1'b1;
      else if (clr_i[g])   pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_entry_pkg::*;
#(
  parameter int N = N_MASKABLE
) (
  input  logic [N-1:0] pend_i,
  input  logic         ee_i,
  input  logic         trap_i,
  input  logic         sc_i,
  output exc_kind_e    kind_o,
  output logic [N-1:0] clr_o
);
  logic [N-1:0] lowest;

  always_comb begin
    lowest = pend_i & (~pend_i + N'(1));
    clr_o  = '0;
    kind_o = EK_NONE;
    if (trap_i) begin
      kind_o = EK_TRAP;
    end else if (sc_i) begin
      kind_o = EK_SC;
    end else if (ee_i) begin
      clr_o = lowest;
      for (int i = 0; i < N; i++) begin
        if (lowest[i]) kind_o = exc_kind_e'(3'(i + 1));
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter logic [31:0] RESET_PC   = 32'hFFF0_0100,
  parameter logic [31:0] RESET_MSR  = 32'h0000_0040,
  parameter logic [31:0] HIGH_BASE  = 32'hFFF0_0000,
  parameter logic [31:0] IMPL_RESET = 32'h0000_0001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_req_i,
  input  logic                  dec_req_i,
  input  logic                  smi_req_i,
  input  logic                  trap_i,
  input  logic                  syscall_i,
  input  logic [31:0]           cur_pc_i,
  input  logic [31:0]           nxt_pc_i,
  input  logic [31:0]           ibr_i,
  input  logic                  msr_we_i,
  input  logic [31:0]           msr_wdata_i,
  output logic                  redirect_o,
  output logic [31:0]           redirect_pc_o,
  output logic [31:0]           srr0_o,
  output logic [31:0]           srr1_o,
  output logic [31:0]           msr_o,
  output logic [N_MASKABLE-1:0] pending_o,
  output logic [31:0]           impl_cfg_o
);
  localparam int NS = N_MASKABLE;

  logic [NS-1:0] req_set;
  logic [NS-1:0] pend_q;
  logic [NS-1:0] svc_clr;
  exc_kind_e     entry_kind;
  logic          entry_take;
  logic          entry_is_trap;

  logic [31:0] msr_q, pc_q, srr0_q, srr1_q, impl_q;
  logic        redir_q;

  assign req_set = {smi_req_i, dec_req_i, ext_req_i};

  exc_pend_reg #(.N(NS)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (req_set),
    .clr_i  (svc_clr),
    .pend_o (pend_q)
  );

  exc_prio_sel #(.N(NS)) u_sel (
    .pend_i (pend_q),
    .ee_i   (msr_q[MB_EE]),
    .trap_i (trap_i),
    .sc_i   (syscall_i),
    .kind_o (entry_kind),
    .clr_o  (svc_clr)
  );

  assign entry_take    = (entry_kind != EK_NONE);
  assign entry_is_trap = (entry_kind == EK_TRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr_q   <= RESET_MSR;
      pc_q    <= RESET_PC;
      srr0_q  <= '0;
      srr1_q  <= '0;
      redir_q <= 1'b0;
      impl_q  <= IMPL_RESET;
    end else begin
      redir_q <= entry_take;
      if (entry_take) begin
        msr_q  <= msr_on_entry(msr_q);
        srr0_q <= entry_is_trap ? cur_pc_i : nxt_pc_i;
        srr1_q <= srr1_on_entry(msr_q, entry_is_trap);
        pc_q   <= vector_addr(msr_q, ibr_i, vec_offset(entry_kind), HIGH_BASE);
      end else if (msr_we_i) begin
        msr_q  <= msr_wdata_i;
      end
    end
  end

  assign redirect_o    = redir_q;
  assign redirect_pc_o = pc_q;
  assign srr0_o        = srr0_q;
  assign srr1_o        = srr1_q;
  assign msr_o         = msr_q;
  assign pending_o     = pend_q;
  assign impl_cfg_o    = impl_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_req_i,
  input logic        trap_i,
  input logic        syscall_i,
  input logic        msr_we_i,
  input logic [31:0] cur_pc_i,
  input logic        redirect_o,
  input logic [31:0] srr1_o,
  input logic [31:0] srr0_o,
  input logic [31:0] msr_o,
  input logic [2:0]  pending_o,
  input logic [2:0]  clr_w,
  input logic        take_w
);
  p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_w));

  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_o[15] && !trap_i && !syscall_i) |=> !redirect_o);

  p_ext_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[15] && pending_o[0] && !trap_i && !syscall_i && !ext_req_i)
      |=> (redirect_o && !pending_o[0]));

  p_sync_keeps_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i || syscall_i) |=> (redirect_o && (($past(pending_o) & ~pending_o) == 3'b000)));

  p_srr1_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> ((srr1_o & ~32'h0002_FF73) == 32'h0));

  p_trap_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (srr0_o == $past(cur_pc_i)));

  p_msr_rewrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (((msr_o & 32'h0004_EF32) == 32'h0) && (msr_o[0] == msr_o[16])));

  p_msr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_we_i && !take_w) |=> $stable(msr_o));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_req_i  (ext_req_i),
  .trap_i     (trap_i),
  .syscall_i  (syscall_i),
  .msr_we_i   (msr_we_i),
  .cur_pc_i   (cur_pc_i),
  .redirect_o (redirect_o),
  .srr1_o     (srr1_o),
  .srr0_o     (srr0_o),
  .msr_o      (msr_o),
  .pending_o  (pending_o),
  .clr_w      (svc_clr),
  .take_w     (entry_take)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_req_i = 0, dec_req_i = 0, smi_req_i = 0, trap_i = 0, syscall_i = 0;
  logic [31:0] cur_pc_i = 32'h0000_2000, nxt_pc_i = 32'h0000_2004, ibr_i = 32'h0012_0000;
  logic        msr_we_i = 0;
  logic [31:0] msr_wdata_i = '0;
  logic        redirect_o;
  logic [31:0] redirect_pc_o, srr0_o, srr1_o, msr_o, impl_cfg_o;
  logic [2:0]  pending_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  localparam logic [31:0] W_LOW = 32'h0001_FF37;
  localparam logic [31:0] W_HI  = 32'h0000_8040;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ext_req_i(ext_req_i), .dec_req_i(dec_req_i), .smi_req_i(smi_req_i),
    .trap_i(trap_i), .syscall_i(syscall_i),
    .cur_pc_i(cur_pc_i), .nxt_pc_i(nxt_pc_i), .ibr_i(ibr_i),
    .msr_we_i(msr_we_i), .msr_wdata_i(msr_wdata_i),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o),
    .pending_o(pending_o), .impl_cfg_o(impl_cfg_o)
  );

  // independent restatement of the entry rewrite, bit by bit
  function automatic logic [31:0] model_msr(input logic [31:0] m);
    logic [31:0] r;
    r = m;
    r[18] = 0; r[15] = 0; r[14] = 0; r[13] = 0; r[11] = 0; r[10] = 0;
    r[9] = 0;  r[8] = 0;  r[5] = 0;  r[4] = 0;  r[1] = 0;
    r[0] = m[16];
    return r;
  endfunction

  function automatic logic [31:0] model_srr1(input logic [31:0] m, input bit trap);
    return (m & 32'h0000_FF73) + (trap ? 32'h0002_0000 : 32'h0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_msr(input logic [31:0] v);
    msr_we_i = 1; msr_wdata_i = v;
    step();
    msr_we_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 pc",       redirect_pc_o, 32'hFFF0_0100);
    chk("R1 msr",      msr_o, 32'h0000_0040);
    chk("R1 pending",  {29'd0, pending_o}, 32'h0);
    chk("R1 impl",     impl_cfg_o, 32'h1);
    chk("R10 idle",    {31'd0, redirect_o}, 32'h0);
  endtask

  task automatic t_masked_latch();
    ext_req_i = 1; dec_req_i = 1; smi_req_i = 1;
    step();
    ext_req_i = 0; dec_req_i = 0; smi_req_i = 0;
    chk("R2 latch",    {29'd0, pending_o}, 32'h7);
    chk("R3 no entry", {31'd0, redirect_o}, 32'h0);
    step(); step();
    chk("R3 still masked", {31'd0, redirect_o}, 32'h0);
    chk("R2 held",     {29'd0, pending_o}, 32'h7);
  endtask

  task automatic t_priority();
    logic [15:0] offs [3] = '{16'h0500, 16'h0900, 16'h1400};
    logic [2:0]  left [3] = '{3'b110, 3'b100, 3'b000};
    for (int s = 0; s < 3; s++) begin
      write_msr(W_LOW);
      chk("R11 write", msr_o, W_LOW);
      chk("R10 low before", {31'd0, redirect_o}, 32'h0);
      step();
      chk("R10 strobe", {31'd0, redirect_o}, 32'h1);
      chk("R9 vector ibr", redirect_pc_o, ibr_i | {16'h0, offs[s]});
      chk("R4 order", {29'd0, pending_o}, {29'd0, left[s]});
      chk("R7 next pc", srr0_o, nxt_pc_i);
      chk("R6 srr1", srr1_o, model_srr1(W_LOW, 0));
      chk("R8 msr", msr_o, model_msr(W_LOW));
      step();
      chk("R10 one cycle", {31'd0, redirect_o}, 32'h0);
    end
  endtask

  task automatic t_high_base();
    dec_req_i = 1; step(); dec_req_i = 0;
    write_msr(W_HI);
    step();
    chk("R9 high base", redirect_pc_o, 32'hFFF0_0900);
    chk("R8 msr hi", msr_o, model_msr(W_HI));
    chk("R4 dec cleared", {29'd0, pending_o}, 32'h0);
  endtask

  task automatic t_trap_masked();
    ext_req_i = 1; step(); ext_req_i = 0;
    cur_pc_i = 32'h0000_3000; nxt_pc_i = 32'h0000_3004;
    trap_i = 1; step(); trap_i = 0;
    chk("R5 trap taken", {31'd0, redirect_o}, 32'h1);
    chk("R7 trap pc", srr0_o, 32'h0000_3000);
    chk("R6 trap flag", srr1_o, model_srr1(32'h0000_0040, 1));
    chk("R9 trap vector", redirect_pc_o, 32'hFFF0_0700);
    chk("R5 pending kept", {29'd0, pending_o}, 32'h1);
  endtask

  task automatic t_sc_over_irq();
    write_msr(W_LOW);
    syscall_i = 1; step(); syscall_i = 0;
    chk("R9 sc vector", redirect_pc_o, ibr_i | 32'h0C00);
    chk("R6 sc no flag", srr1_o, model_srr1(W_LOW, 0));
    chk("R7 sc next pc", srr0_o, 32'h0000_3004);
    chk("R5 sc beats irq", {29'd0, pending_o}, 32'h1);
    step();
    chk("R3 ee cleared", {31'd0, redirect_o}, 32'h0);
  endtask

  task automatic t_trap_over_sc();
    logic [31:0] m;
    m = msr_o;
    trap_i = 1; syscall_i = 1; step(); trap_i = 0; syscall_i = 0;
    chk("R5 trap wins", redirect_pc_o, ibr_i | 32'h0700);
    chk("R6 trap wins flag", srr1_o, model_srr1(m, 1));
  endtask

  task automatic t_write_vs_entry();
    logic [31:0] m;
    m = msr_o;
    syscall_i = 1; msr_we_i = 1; msr_wdata_i = 32'hFFFF_FFFF;
    step();
    syscall_i = 0; msr_we_i = 0;
    chk("R11 entry wins", msr_o, model_msr(m));
    write_msr(W_LOW);
    step();
    chk("R4 ext served", redirect_pc_o, ibr_i | 32'h0500);
    chk("R4 all clear", {29'd0, pending_o}, 32'h0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_masked_latch();
    t_priority();
    t_high_base();
    t_trap_masked();
    t_sc_over_irq();
    t_trap_over_sc();
    t_write_vs_entry();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule